// File: doc/BRIEF.md
# Self-Disarming Up-Counting Interrupt Timer

This block is a 16-bit interrupt timer that sits on the CPU register bus. Software sets a start value with two byte writes. The low byte goes to 0x4502. The high byte goes to 0x4503, and that write also arms the timer. Once armed, the timer counts upward by one on each counting clock. When a counting clock arrives while the count already sits at 0xFFFF, the timer does not wrap. It drops its armed flag and raises its interrupt line instead. A write to 0x4501 stops the timer without firing it.

The counting clock has two sources, and bit 3 of a byte-wide mode register at 0x4500 picks between them. The first source is every CPU cycle, which is every rising edge of `clk`. The second is each rising edge of the PPU's address line A12, which gives eight counts per scanline. The A12 input is synchronised and edge-detected inside the block, so a single low-to-high transition counts exactly once no matter how long the line stays high.

The interrupt output is a level. It stays high until software acknowledges it. Several writes acknowledge it: writes to 0x4501, 0x4502 and 0x4503, and also writes to 0x4024 and 0x4025.

Top module: `irq_upcount_timer`

## Requirements
- R1: After reset, `irq` is 0, the timer is disarmed, the count is 0, and a read of 0x4500 returns 0x00.
- R2: A write to 0x4502 loads the count's low byte. A write to 0x4503 loads the high byte and arms the timer. With CPU-cycle counting and a start value S, `irq` rises at the (65536 − S)-th clock edge after the edge that takes the 0x4503 write.
- R3: When the timer fires, it disarms itself. After that interrupt is acknowledged, `irq` stays low for as long as no new 0x4503 write arrives.
- R4: A write to 0x4501 disarms the timer. No interrupt follows while the timer is disarmed.
- R5: `irq` is a level that stays high until a write to one of 0x4024, 0x4025, 0x4501, 0x4502 or 0x4503. It is low from the edge after any such write. A clock edge that takes one of these writes is not a counting clock.
- R6: Mode bit 3 = 0 selects CPU-cycle counting. Mode bit 3 = 1 selects counting on A12 rising edges. In A12 mode, CPU cycles alone do not advance the count.
- R7: The mode register at 0x4500 holds the last byte written to it, and reading 0x4500 returns that byte. A read of any other address returns 0x00.
- R8: In A12 mode, each low-to-high transition of `ppu_a12` advances the count exactly once, however long the line then stays high.
- R9: Writes to addresses outside the listed registers leave `irq` and the count unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock; each rising edge is one CPU cycle |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken on the rising edge |
| bus_addr | input | 16 | CPU register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from `bus_addr` |
| ppu_a12 | input | 1 | PPU address line A12, asynchronous |
| irq | output | 1 | Interrupt request level |

## Verification
The hardest state to reach from the ports is the fire-and-disarm edge. Once the timer fires, the count is parked at 0xFFFF with no way to read it, and a fault that leaves the timer armed would re-fire at once. The stimulus therefore loads start values just below 0xFFFF, including 0xFFFF itself, and measures the exact edge on which `irq` rises. After acknowledging the interrupt, it waits a long idle stretch to show the line stays low. In A12 mode, shaped pulses, including one deliberately long pulse, show that each transition counts once and that CPU cycles alone do not count.

// File: rtl/irqt_pkg.sv
package irqt_pkg;

    localparam logic [15:0] ADR_MODE = 16'h4500;
    localparam logic [15:0] ADR_STOP = 16'h4501;
    localparam logic [15:0] ADR_LO   = 16'h4502;
    localparam logic [15:0] ADR_HI   = 16'h4503;
    localparam logic [15:0] ADR_AUXA = 16'h4024;
    localparam logic [15:0] ADR_AUXB = 16'h4025;

    localparam int MODE_SRC_BIT = 3;

    typedef enum logic {
        SRC_CPU = 1'b0,
        SRC_A12 = 1'b1
    } clk_src_t;

    typedef struct packed {
        logic mode_wr;
        logic load_lo;
        logic load_hi;
        logic stop;
        logic ack;
    } bus_op_t;

    function automatic bus_op_t decode_op(input logic wr, input logic [15:0] addr);
        bus_op_t op;
        op.mode_wr = wr && (addr == ADR_MODE);
        op.load_lo = wr && (addr == ADR_LO);
        op.load_hi = wr && (addr == ADR_HI);
        op.stop    = wr && (addr == ADR_STOP);
        op.ack     = op.load_lo || op.load_hi || op.stop ||
                     (wr && ((addr == ADR_AUXA) || (addr == ADR_AUXB)));
        return op;
    endfunction

endpackage

// File: rtl/irqt_edge_det.sv
module irqt_edge_det #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[TOP];
    end

    assign rise = sync_q[TOP] && !prev_q;
endmodule

// File: rtl/irqt_count_core.sv
module irqt_count_core
    import irqt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  bus_op_t           op,
    input  logic [DATA_W-1:0] wdata,
    input  logic              tick,
    output logic              armed,
    output logic              irq,
    output logic [2*DATA_W-1:0] count
);
    localparam int CNT_W = 2 * DATA_W;

    logic at_top;
    logic step;

    assign at_top = &count;
    // register writes take the edge; counting waits for the next one
    assign step   = tick && armed && !op.ack;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
            armed <= 1'b0;
            irq   <= 1'b0;
        end else begin
            if (op.ack)     irq <= 1'b0;
            if (op.load_lo) count[DATA_W-1:0] <= wdata;
            if (op.load_hi) begin
                count[CNT_W-1:DATA_W] <= wdata;
                armed <= 1'b1;
            end
            if (op.stop)    armed <= 1'b0;
            if (step) begin
                if (at_top) begin
                    armed <= 1'b0;
                    irq   <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/irq_upcount_timer.sv
module irq_upcount_timer
    import irqt_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [15:0]       bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ppu_a12,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    bus_op_t           op;
    logic [DATA_W-1:0] mode_q;
    clk_src_t          src;
    logic              a12_rise;
    logic              tick;
    logic              armed;
    logic [CNT_W-1:0]  count;

    assign op = decode_op(bus_wr, bus_addr);

    always_ff @(posedge clk) begin
        if (rst)             mode_q <= '0;
        else if (op.mode_wr) mode_q <= bus_wdata;
    end

    assign src       = clk_src_t'(mode_q[MODE_SRC_BIT]);
    assign bus_rdata = (bus_addr == ADR_MODE) ? mode_q : '0;

    irqt_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .din  (ppu_a12),
        .rise (a12_rise)
    );

    assign tick = (src == SRC_A12) ? a12_rise : 1'b1;

    irqt_count_core #(.DATA_W(DATA_W)) u_core (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .wdata (bus_wdata),
        .tick  (tick),
        .armed (armed),
        .irq   (irq),
        .count (count)
    );
endmodule

// File: rtl/irq_timer_chk.sv
module irq_timer_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic        irq,
    input logic        armed,
    input logic [15:0] count
);
    logic ack_wr;
    logic cnt_wr;
    assign ack_wr = bus_wr && (bus_addr == 16'h4024 || bus_addr == 16'h4025 ||
                               bus_addr == 16'h4501 || bus_addr == 16'h4502 ||
                               bus_addr == 16'h4503);
    assign cnt_wr = bus_wr && (bus_addr == 16'h4502 || bus_addr == 16'h4503);

    // R5
    ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ack_wr |=> !irq);
    // R5
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !ack_wr) |=> irq);
    // R2
    arm_on_high_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 16'h4503) |=> armed);
    // R4
    stop_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 16'h4501) |=> !armed);
    // R3
    fire_disarms_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> !armed);
    // R9
    idle_count_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !cnt_wr) |=> $stable(count));
endmodule

bind irq_upcount_timer irq_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .irq      (irq),
    .armed    (armed),
    .count    (count)
);

// File: tb/tb_irq_upcount_timer.sv
module tb_irq_upcount_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic [7:0]  bus_rdata;
    logic        ppu_a12 = 1'b0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    irq_upcount_timer dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ppu_a12(ppu_a12), .irq(irq)
    );

    function automatic int edges_to_fire(input logic [15:0] start);
        return 65536 - int'(start);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 16'h0000;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic arm(input logic [15:0] s);
        bus_write(16'h4502, s[7:0]);
        bus_write(16'h4503, s[15:8]);
    endtask

    task automatic a12_pulse(input int high_cycles);
        @(negedge clk); ppu_a12 = 1'b1;
        repeat (high_cycles) @(negedge clk);
        ppu_a12 = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // CPU mode: irq low one edge before the expected edge, high on it
    task automatic cpu_run(input logic [15:0] s, input string tag);
        int n;
        n = edges_to_fire(s);
        arm(s);
        for (int k = 1; k <= n; k++) begin
            @(negedge clk);
            if (k == n - 1) chk({tag, " irq before expected edge"}, int'(irq), 0);
            if (k == n)     chk({tag, " irq on expected edge"}, int'(irq), 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] ack_addrs [5];
        void'($urandom(32'd2024));
        ack_addrs[0] = 16'h4024; ack_addrs[1] = 16'h4025; ack_addrs[2] = 16'h4501;
        ack_addrs[3] = 16'h4502; ack_addrs[4] = 16'h4503;

        idle(3);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq after reset", int'(irq), 0);
        bus_addr = 16'h4500; #1;
        chk("R1 mode read after reset", int'(bus_rdata), 0);
        bus_addr = 16'h0000;
        idle(50);
        chk("R1 no irq while disarmed", int'(irq), 0);

        // R7 mode readback with bit 3 clear, other address reads zero
        bus_write(16'h4500, 8'h42);
        bus_addr = 16'h4500; #1;
        chk("R7 mode readback", int'(bus_rdata), 8'h42);
        bus_addr = 16'h4501; #1;
        chk("R7 other address reads zero", int'(bus_rdata), 0);
        bus_addr = 16'h0000;

        // R2 directed corners and a far start value
        cpu_run(16'hFFFF, "R2 start FFFF");
        bus_write(16'h4024, 8'h00);
        cpu_run(16'hFFFE, "R2 start FFFE");
        // R5 level holds without ack
        idle(20);
        chk("R5 irq held without ack", int'(irq), 1);
        // R9 unrelated write does not ack
        bus_write(16'h4504, 8'h55);
        chk("R9 unrelated write leaves irq", int'(irq), 1);
        bus_write(16'h4025, 8'h00);
        chk("R5 ack via 4025", int'(irq), 0);
        // R3 disarmed after fire: no refire
        idle(300);
        chk("R3 no refire after ack", int'(irq), 0);

        cpu_run(16'hF000, "R2 start F000");
        bus_write(16'h4024, 8'h00);
        chk("R5 ack via 4024", int'(irq), 0);

        // R2/R5 random start values and random ack addresses
        for (int i = 0; i < 10; i++) begin
            logic [15:0] s;
            int a;
            s = 16'hFFFE - 16'($urandom_range(0, 250));
            cpu_run(s, "R2 random start");
            a = int'($urandom_range(0, 4));
            bus_write(ack_addrs[a], 8'hFF);
            chk("R5 random ack", int'(irq), 0);
            if (a == 4) bus_write(16'h4501, 8'h00); // re-armed by 4503; stop it
        end

        // R4 disable before firing
        arm(16'hFFF0);
        idle(5);
        bus_write(16'h4501, 8'h00);
        idle(100);
        chk("R4 stopped timer stays quiet", int'(irq), 0);

        // R6 A12 mode: CPU cycles alone do not count
        bus_write(16'h4500, 8'h08);
        bus_addr = 16'h4500; #1;
        chk("R7 mode readback A12", int'(bus_rdata), 8'h08);
        bus_addr = 16'h0000;
        arm(16'hFFF8);
        idle(200);
        chk("R6 no count on CPU cycles in A12 mode", int'(irq), 0);
        for (int p = 1; p <= edges_to_fire(16'hFFF8); p++) begin
            a12_pulse(3);
            if (p == edges_to_fire(16'hFFF8) - 1) chk("R6 A12 before last edge", int'(irq), 0);
            if (p == edges_to_fire(16'hFFF8))     chk("R6 A12 fire on last edge", int'(irq), 1);
        end
        bus_write(16'h4501, 8'h00);
        chk("R5 ack via 4501", int'(irq), 0);

        // R8 one long pulse counts once
        arm(16'hFFFE);
        a12_pulse(40);
        chk("R8 long pulse counts once", int'(irq), 0);
        a12_pulse(3);
        chk("R8 second edge fires", int'(irq), 1);
        bus_write(16'h4502, 8'h00);
        chk("R5 ack via 4502", int'(irq), 0);

        // R9 unrelated write during armed count does not change timing
        bus_write(16'h4500, 8'h00);
        arm(16'hFFF0);
        bus_write(16'h4510, 8'h77);
        // 16 edges after arm; the 4510 write consumed 2 of them
        idle(edges_to_fire(16'hFFF0) - 3);
        chk("R9 count unaffected before fire", int'(irq), 0);
        idle(1);
        chk("R9 count unaffected at fire", int'(irq), 1);
        bus_write(16'h4024, 8'h00);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule